// File: doc/BRIEF.md
# Banked BCD Calendar Register File

This block is the time-keeping core of a real-time clock. It sits behind a narrow parallel register port with a 4-bit address, separate read and write strobes and a 4-bit data nibble. It keeps seconds, minutes and hours (24-hour), a day-of-week counter, day of month, month and a four-digit year, and stores each decimal digit in its own 4-bit register. An external one-pulse-per-second strobe drives it. Each accepted pulse advances the calendar by one second, with carries through every digit, month lengths and the Gregorian leap-year rule.

Software sees four banks of fifteen nibble registers. A control register sits at the top address and looks the same in every bank. It holds the bank selector, a stop bit that freezes the clock while digits are loaded, and a read-only busy bit that stays high for a short window after each update. Software polls busy until it reads 0 before it reads the time. Bank 1 holds the registers of a separate alarm comparator, and bank 2 holds a timer control nibble. This block stores those registers and drives them out. The matching logic lives elsewhere.

Top module: `bcd_rtc_regfile`

## Requirements
- R1: After reset, the control register reads 0 (bank 0, running, not busy), and the time is 2000-01-01 00:00:00 with day of week 0.
- R2: `rdData` is zero while `rdStb` is low. While `rdStb` is high, the upper `DATA_W-4` bits are zero and the nibble sits in bits 3:0. In bank 3, every address except 0xF reads 0.
- R3: In bank 0, addresses 0x0 to 0xE hold, in this order: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, day of week, day units, day tens, month units, month tens, and then the year units, tens, hundreds and thousands. A write takes effect at the clock edge that samples `wrStb`. `timeDigits[4*i+3:4*i]` mirrors address i.
- R4: Address 0xF is the control register in every bank. Bit 0 is busy, bit 1 is stop, and bits 3:2 are the bank number, with bit 2 as the low bit. Writes to bit 0 are ignored.
- R5: A tick that arrives while stop is 1 is discarded. The digits do not change, and the tick is not applied after stop clears.
- R6: After an accepted tick, the digits are updated at that edge, and busy reads 1 for exactly 2 cycles and then reads 0.
- R7: Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into the day. Day of week counts 0 to 6 and then wraps to 0.
- R8: After the last day of a month, the day returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days, and the other months except February have 31. Month 12 wraps to 1 and carries into the year, which counts 0000 to 9999 in decimal.
- R9: February has 29 days when the year is divisible by 4 and is not a century year, or when it is a century year divisible by 400. Otherwise it has 28.
- R10: Bank 1 addresses 0x0 to 0xE are 15 writable nibbles, readable back and driven on `alarmRegs`. Bank 2 address 0xE is a 2-bit timer control (bit 0 enable, bit 1 flag) driven on `timerCtrl`. Other bank-2 addresses read 0.
- R11: When a tick and a write to a bank-0 digit fall in the same cycle, every digit takes its advanced value except the written digit, which takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| addr | input | 4 | Register address within the selected bank |
| wrStb | input | 1 | Write strobe |
| wrData | input | 4 | Write nibble |
| rdStb | input | 1 | Read strobe |
| rdData | output | DATA_W | Read data, nibble in bits 3:0 |
| timeDigits | output | 60 | All 15 time digits, address i in bits 4i+3:4i |
| alarmRegs | output | 60 | All 15 bank-1 nibbles for the alarm comparator |
| timerCtrl | output | 2 | Bank-2 timer control bits |

## Verification
A second tick and a software digit write can land on the same clock edge. The increment path and the write port then both want to load the digit array. The bench provokes this by raising `secTick` in the same cycle as a write to the minutes-units digit, with the seconds at 59, so the increment also carries into that same digit. It then checks that the seconds wrapped, that every other digit took its advanced value, and that the written minutes value replaced the carried one. A stop-bit write paired with a pending tick is also exercised.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int NIB_W   = 4;
  localparam int NUM_DIG = 15;

  // strobes from control to datapath
  typedef struct packed {
    logic       advance;
    logic       wrDigit;
    logic       wrAlarm;
    logic       wrTimer;
    logic [3:0] idx;
    logic [3:0] data;
  } rtc_stb_t;

  // digit index map of bank 0
  localparam int D_S1 = 0, D_S10 = 1, D_M1 = 2, D_M10 = 3, D_H1 = 4, D_H10 = 5,
                 D_DOW = 6, D_D1 = 7, D_D10 = 8, D_MO1 = 9, D_MO10 = 10,
                 D_Y1 = 11, D_Y10 = 12, D_Y100 = 13, D_Y1000 = 14;
endpackage

// File: rtl/bcd_rtc_ctrl.sv
module bcd_rtc_ctrl
  import bcd_rtc_pkg::*;
#(
  parameter int BUSY_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic [3:0] addr,
  input  logic       wrStb,
  input  logic [3:0] wrData,
  output rtc_stb_t   stb,
  output logic       stopQ,
  output logic       busy,
  output logic [1:0] bankQ,
  output logic [3:0] ctrlNib
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYC);

  logic [CW-1:0] busyCnt;
  logic          isCtrl;

  always_comb begin
    isCtrl      = (addr == 4'hF);
    stb.advance = secTick & ~stopQ;
    stb.wrDigit = wrStb & ~isCtrl & (bankQ == 2'd0);
    stb.wrAlarm = wrStb & ~isCtrl & (bankQ == 2'd1);
    stb.wrTimer = wrStb & (addr == 4'hE) & (bankQ == 2'd2);
    stb.idx     = addr;
    stb.data    = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopQ   <= 1'b0;
      bankQ   <= 2'd0;
      busyCnt <= '0;
    end else begin
      if (wrStb && isCtrl) begin
        stopQ <= wrData[1];
        bankQ <= wrData[3:2];
      end
      if (stb.advance)
        busyCnt <= BUSY_LOAD;
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy    = (busyCnt != '0);
  assign ctrlNib = {bankQ, stopQ, busy};
endmodule

// File: rtl/bcd_rtc_datapath.sv
module bcd_rtc_datapath
  import bcd_rtc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  rtc_stb_t                 stb,
  input  logic [1:0]               bank,
  input  logic [3:0]               addr,
  output logic [3:0]               rdNib,
  output logic [NUM_DIG*NIB_W-1:0] timeDigits,
  output logic [NUM_DIG*NIB_W-1:0] alarmRegs,
  output logic [1:0]               timerCtrl
);
  logic [3:0] tDig [NUM_DIG];
  logic [3:0] nxt  [NUM_DIG];
  logic [3:0] aDig [NUM_DIG];
  logic [1:0] timerQ;
  logic [6:0] yLow, yHigh;
  logic [4:0] monBin, dayBin, lastDay;
  logic       leap, carry;

  function automatic logic [3:0] rstVal(input int i);
    case (i)
      D_D1, D_MO1: return 4'd1;
      D_Y1000:     return 4'd2;
      default:     return 4'd0;
    endcase
  endfunction

  // month length and leap rule
  always_comb begin
    yLow   = {3'b0, tDig[D_Y10]} * 7'd10 + {3'b0, tDig[D_Y1]};
    yHigh  = {3'b0, tDig[D_Y1000]} * 7'd10 + {3'b0, tDig[D_Y100]};
    leap   = (yLow[1:0] == 2'b00) && ((yLow != 7'd0) || (yHigh[1:0] == 2'b00));
    monBin = {1'b0, tDig[D_MO10]} * 5'd10 + {1'b0, tDig[D_MO1]};
    dayBin = {1'b0, tDig[D_D10]} * 5'd10 + {1'b0, tDig[D_D1]};
    case (monBin)
      5'd2:                     lastDay = leap ? 5'd29 : 5'd28;
      5'd4, 5'd6, 5'd9, 5'd11:  lastDay = 5'd30;
      default:                  lastDay = 5'd31;
    endcase
  end

  // one-second ripple increment
  always_comb begin
    for (int i = 0; i < NUM_DIG; i++) nxt[i] = tDig[i];
    carry = 1'b1;
    for (int p = 0; p < 2; p++) begin
      if (carry) begin
        if (nxt[2*p] == 4'd9) begin
          nxt[2*p] = 4'd0;
          if (nxt[2*p+1] == 4'd5) nxt[2*p+1] = 4'd0;
          else begin nxt[2*p+1] = nxt[2*p+1] + 4'd1; carry = 1'b0; end
        end else begin
          nxt[2*p] = nxt[2*p] + 4'd1; carry = 1'b0;
        end
      end
    end
    if (carry) begin
      if (tDig[D_H10] == 4'd2 && tDig[D_H1] == 4'd3) begin
        nxt[D_H10] = 4'd0; nxt[D_H1] = 4'd0;
      end else if (tDig[D_H1] == 4'd9) begin
        nxt[D_H1] = 4'd0; nxt[D_H10] = tDig[D_H10] + 4'd1; carry = 1'b0;
      end else begin
        nxt[D_H1] = tDig[D_H1] + 4'd1; carry = 1'b0;
      end
    end
    if (carry) begin
      nxt[D_DOW] = (tDig[D_DOW] >= 4'd6) ? 4'd0 : tDig[D_DOW] + 4'd1;
      if (dayBin >= lastDay) begin
        nxt[D_D10] = 4'd0; nxt[D_D1] = 4'd1;
      end else if (tDig[D_D1] == 4'd9) begin
        nxt[D_D1] = 4'd0; nxt[D_D10] = tDig[D_D10] + 4'd1; carry = 1'b0;
      end else begin
        nxt[D_D1] = tDig[D_D1] + 4'd1; carry = 1'b0;
      end
    end
    if (carry) begin
      if (monBin >= 5'd12) begin
        nxt[D_MO10] = 4'd0; nxt[D_MO1] = 4'd1;
      end else if (tDig[D_MO1] == 4'd9) begin
        nxt[D_MO1] = 4'd0; nxt[D_MO10] = 4'd1; carry = 1'b0;
      end else begin
        nxt[D_MO1] = tDig[D_MO1] + 4'd1; carry = 1'b0;
      end
    end
    for (int y = D_Y1; y <= D_Y1000; y++) begin
      if (carry) begin
        if (tDig[y] == 4'd9) nxt[y] = 4'd0;
        else begin nxt[y] = tDig[y] + 4'd1; carry = 1'b0; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DIG; i++) begin
        tDig[i] <= rstVal(i);
        aDig[i] <= 4'd0;
      end
      timerQ <= 2'd0;
    end else begin
      if (stb.advance)
        for (int i = 0; i < NUM_DIG; i++) tDig[i] <= nxt[i];
      if (stb.wrDigit && stb.idx != 4'hF) tDig[stb.idx] <= stb.data;
      if (stb.wrAlarm && stb.idx != 4'hF) aDig[stb.idx] <= stb.data;
      if (stb.wrTimer) timerQ <= stb.data[1:0];
    end
  end

  always_comb begin
    rdNib = 4'd0;
    if (addr != 4'hF) begin
      case (bank)
        2'd0:    rdNib = tDig[addr];
        2'd1:    rdNib = aDig[addr];
        2'd2:    rdNib = (addr == 4'hE) ? {2'b00, timerQ} : 4'd0;
        default: rdNib = 4'd0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_flat
    assign timeDigits[g*NIB_W +: NIB_W] = tDig[g];
    assign alarmRegs[g*NIB_W +: NIB_W]  = aDig[g];
  end
  assign timerCtrl = timerQ;
endmodule

// File: rtl/bcd_rtc_regfile.sv
module bcd_rtc_regfile
  import bcd_rtc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [3:0]        addr,
  input  logic              wrStb,
  input  logic [3:0]        wrData,
  input  logic              rdStb,
  output logic [DATA_W-1:0] rdData,
  output logic [59:0]       timeDigits,
  output logic [59:0]       alarmRegs,
  output logic [1:0]        timerCtrl
);
  localparam int PAD_W = DATA_W - NIB_W;

  rtc_stb_t   stb;
  logic       stopQ, busyQ;
  logic [1:0] bankQ;
  logic [3:0] ctrlNib, dpNib, rdNib;

  bcd_rtc_ctrl #(.BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .addr(addr), .wrStb(wrStb),
    .wrData(wrData), .stb(stb), .stopQ(stopQ), .busy(busyQ), .bankQ(bankQ),
    .ctrlNib(ctrlNib)
  );

  bcd_rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bank(bankQ), .addr(addr),
    .rdNib(dpNib), .timeDigits(timeDigits), .alarmRegs(alarmRegs),
    .timerCtrl(timerCtrl)
  );

  assign rdNib  = (addr == 4'hF) ? ctrlNib : dpNib;
  assign rdData = rdStb ? {{PAD_W{1'b0}}, rdNib} : '0;
endmodule

// File: rtl/bcd_rtc_regfile_chk.sv
module bcd_rtc_regfile_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              advance,
  input logic              wrDigit,
  input logic              stopQ,
  input logic              busyQ,
  input logic [1:0]        bankQ,
  input logic              wrStb,
  input logic [3:0]        addr,
  input logic              rdStb,
  input logic [DATA_W-1:0] rdData,
  input logic [59:0]       timeDigits
);
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |-> rdData == '0);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:4] == '0);

  a_r5_stopped_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && !wrDigit) |=> $stable(timeDigits));

  a_r6_busy_from_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(advance));

  a_r6_busy_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |=> busyQ);

  a_r6_tick_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> busyQ);

  a_r4_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb && addr == 4'hF) |=> $stable(bankQ) && $stable(stopQ));
endmodule

bind bcd_rtc_regfile bcd_rtc_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .advance(stb.advance), .wrDigit(stb.wrDigit),
  .stopQ(stopQ), .busyQ(busyQ), .bankQ(bankQ), .wrStb(wrStb), .addr(addr),
  .rdStb(rdStb), .rdData(rdData), .timeDigits(timeDigits)
);

// File: tb/sim_bcd_rtc_regfile.sv
`timescale 1ns/1ps
module sim_bcd_rtc_regfile;
  logic        clk = 1'b0, rstN = 1'b0, secTick = 1'b0;
  logic [3:0]  addr = 4'd0, wrData = 4'd0;
  logic        wrStb = 1'b0, rdStb = 1'b0;
  logic [7:0]  rdData;
  logic [59:0] timeDigits, alarmRegs;
  logic [1:0]  timerCtrl;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_rtc_regfile #(.DATA_W(8), .BUSY_CYC(2)) u0 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .addr(addr), .wrStb(wrStb),
    .wrData(wrData), .rdStb(rdStb), .rdData(rdData), .timeDigits(timeDigits),
    .alarmRegs(alarmRegs), .timerCtrl(timerCtrl)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [59:0] pack(input int y, mo, d, dow, h, mi, s);
    return {4'(y/1000), 4'((y/100)%10), 4'((y/10)%10), 4'(y%10),
            4'(mo/10), 4'(mo%10), 4'(d/10), 4'(d%10), 4'(dow),
            4'(h/10), 4'(h%10), 4'(mi/10), 4'(mi%10), 4'(s/10), 4'(s%10)};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); addr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic rdNow(input logic [3:0] a, output logic [7:0] v);
    addr = a; rdStb = 1'b1; #1; v = rdData; rdStb = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
  endtask

  task automatic setTime(input int y, mo, d, dow, h, mi, s);
    logic [59:0] p;
    p = pack(y, mo, d, dow, h, mi, s);
    wr(4'hF, 4'b0010);
    for (int i = 0; i < 15; i++) wr(4'(i), p[4*i +: 4]);
    wr(4'hF, 4'b0000);
  endtask

  task automatic stepCheck(input int y, mo, d, dow, h, mi, s,
                           input int ey, emo, ed, edow, eh, emi, es, input string tag);
    setTime(y, mo, d, dow, h, mi, s);
    tick();
    chk(timeDigits == pack(ey, emo, ed, edow, eh, emi, es), tag, timeDigits,
        pack(ey, emo, ed, edow, eh, emi, es));
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(timeDigits == pack(2000, 1, 1, 0, 0, 0, 0), "R1 reset time", timeDigits,
        pack(2000, 1, 1, 0, 0, 0, 0));
    rdNow(4'hF, v);
    chk(v == 8'h00, "R1 reset control", v, 8'h00);
    addr = 4'hF; #1;
    chk(rdData == 8'h00, "R2 idle read zero", rdData, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] v;
    wr(4'hF, 4'b0010);
    for (int i = 0; i < 15; i++) wr(4'(i), 4'(i) ^ 4'hA);
    for (int i = 0; i < 15; i++) begin
      rdNow(4'(i), v);
      chk(v == {4'h0, 4'(i) ^ 4'hA}, "R3 R2 bank0 readback", v, {4'h0, 4'(i) ^ 4'hA});
      chk(timeDigits[4*i +: 4] == (4'(i) ^ 4'hA), "R3 digit position",
          timeDigits[4*i +: 4], 4'(i) ^ 4'hA);
    end
    wr(4'hF, 4'b0000);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(4'hF, 4'b1111);
    rdNow(4'hF, v);
    chk(v == 8'h0E, "R4 control bank3 stop busy ignored", v, 8'h0E);
    rdNow(4'h3, v);
    chk(v == 8'h00, "R2 bank3 reads zero", v, 8'h00);
    wr(4'hF, 4'b1000);
    rdNow(4'hF, v);
    chk(v == 8'h08, "R4 control seen in bank2", v, 8'h08);
    wr(4'hF, 4'b0001);
    rdNow(4'hF, v);
    chk(v == 8'h00, "R4 write to busy ignored", v, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    setTime(2024, 3, 15, 5, 12, 34, 56);
    wr(4'hF, 4'b0010);
    tick(); tick();
    chk(timeDigits == pack(2024, 3, 15, 5, 12, 34, 56), "R5 stopped ticks dropped",
        timeDigits, pack(2024, 3, 15, 5, 12, 34, 56));
    rdNow(4'hF, v);
    chk(v == 8'h02, "R5 no busy while stopped", v, 8'h02);
    wr(4'hF, 4'b0000);
    repeat (4) @(negedge clk);
    chk(timeDigits == pack(2024, 3, 15, 5, 12, 34, 56), "R5 tick not queued",
        timeDigits, pack(2024, 3, 15, 5, 12, 34, 56));
  endtask

  task automatic t_busy();
    logic [7:0] v;
    tick();
    chk(timeDigits == pack(2024, 3, 15, 5, 12, 34, 57), "R6 digits updated",
        timeDigits, pack(2024, 3, 15, 5, 12, 34, 57));
    rdNow(4'hF, v);
    chk(v == 8'h01, "R6 busy cycle 1", v, 8'h01);
    @(negedge clk); rdNow(4'hF, v);
    chk(v == 8'h01, "R6 busy cycle 2", v, 8'h01);
    @(negedge clk); rdNow(4'hF, v);
    chk(v == 8'h00, "R6 busy cleared", v, 8'h00);
  endtask

  task automatic t_carry();
    stepCheck(2024, 3, 15, 3, 10, 59, 59, 2024, 3, 15, 3, 11, 0, 0, "R7 minute hour carry");
    stepCheck(2024, 3, 16, 6, 23, 59, 59, 2024, 3, 17, 0, 0, 0, 0, "R7 day carry dow wrap");
    stepCheck(2024, 4, 30, 2, 23, 59, 59, 2024, 5, 1, 3, 0, 0, 0, "R8 30-day month");
    stepCheck(2024, 1, 31, 3, 23, 59, 59, 2024, 2, 1, 4, 0, 0, 0, "R8 31-day month");
    stepCheck(2024, 1, 30, 2, 23, 59, 59, 2024, 1, 31, 3, 0, 0, 0, "R8 day 30 of 31");
    stepCheck(1999, 12, 31, 5, 23, 59, 59, 2000, 1, 1, 6, 0, 0, 0, "R8 year carry");
    stepCheck(9999, 12, 31, 1, 23, 59, 59, 0, 1, 1, 2, 0, 0, 0, "R8 year wrap");
  endtask

  task automatic t_leap();
    stepCheck(2024, 2, 28, 3, 23, 59, 59, 2024, 2, 29, 4, 0, 0, 0, "R9 2024 leap");
    stepCheck(2024, 2, 29, 4, 23, 59, 59, 2024, 3, 1, 5, 0, 0, 0, "R9 leap day end");
    stepCheck(2023, 2, 28, 2, 23, 59, 59, 2023, 3, 1, 3, 0, 0, 0, "R9 2023 common");
    stepCheck(2100, 2, 28, 0, 23, 59, 59, 2100, 3, 1, 1, 0, 0, 0, "R9 2100 century");
    stepCheck(2000, 2, 28, 1, 23, 59, 59, 2000, 2, 29, 2, 0, 0, 0, "R9 2000 leap");
  endtask

  task automatic t_banks();
    logic [7:0] v;
    wr(4'hF, 4'b0100);
    for (int i = 0; i < 15; i++) wr(4'(i), 4'(15 - i));
    for (int i = 0; i < 15; i++) begin
      rdNow(4'(i), v);
      chk(v == {4'h0, 4'(15 - i)}, "R10 bank1 readback", v, {4'h0, 4'(15 - i)});
      chk(alarmRegs[4*i +: 4] == 4'(15 - i), "R10 alarmRegs", alarmRegs[4*i +: 4], 4'(15 - i));
    end
    wr(4'hF, 4'b1000);
    wr(4'hE, 4'hB);
    rdNow(4'hE, v);
    chk(v == 8'h03 && timerCtrl == 2'd3, "R10 timer control", {v, 6'd0, timerCtrl}, 16'h0303);
    wr(4'h0, 4'h5);
    rdNow(4'h0, v);
    chk(v == 8'h00, "R10 bank2 other reads zero", v, 8'h00);
    wr(4'hF, 4'b0000);
  endtask

  task automatic t_collide();
    setTime(2024, 1, 1, 1, 10, 20, 59);
    @(negedge clk);
    secTick = 1'b1; addr = 4'h2; wrData = 4'd7; wrStb = 1'b1;
    @(negedge clk);
    secTick = 1'b0; wrStb = 1'b0;
    chk(timeDigits == pack(2024, 1, 1, 1, 10, 27, 0), "R11 tick and write same cycle",
        timeDigits, pack(2024, 1, 1, 1, 10, 27, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_ctrl();
    t_stop();
    t_busy();
    t_carry();
    t_leap();
    t_banks();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule